// File: doc/BRIEF.md
# Pipelined Booth-recoded multiply-adder

This block is an unsigned fused multiply-add datapath. Each accepted operation takes two N-bit operands A and B and a 2N-bit addend C. It returns the 2N-bit value A*B + C, with any carry out of the top bit dropped. The default width is N = 64, which gives a 128-bit result.

The multiplier operand is recoded into radix-4 signed digits, one partial-product row per digit. A row of sign-correction bits, a constant compensation row and the addend row are added to these rows. All of them are registered at the end of the first cycle. In the second cycle a carry-save tree of full-adder levels compresses the rows to two. A parallel-prefix adder then resolves the two rows, and its output is registered.

A parameter selects the prefix network. A second parameter removes the addend, which gives a plain multiplier. A new operation can be issued on every clock, with no stalls.

Top module: `mul_add_pipe`

## Requirements
- R1: With the addend enabled (ADDEND_EN=1), `result` equals (A*B + C) mod 2^(2N), with all operands read as unsigned numbers.
- R2: `outValid` is high in exactly the cycle two clock edges after the edge that sampled `inValid` high, and low in every other cycle. The `result` shown alongside it belongs to that operation.
- R3: An operation is accepted on every cycle that `inValid` is high, including consecutive cycles. Results leave one per cycle, in the order the operations were issued.
- R4: If A and B are all ones and C is all ones, the product-plus-addend wraps. The upper N bits of the result are all ones except their least significant bit, and the lower N bits are zero.
- R5: If A or B is zero, the result equals C exactly.
- R6: With ADDEND_EN=0, `result` equals (A*B) mod 2^(2N), and the value on `addend` has no effect on it.
- R7: PREFIX selects the final adder network: 0 = Kogge-Stone, 1 = Brent-Kung, 2 = Han-Carlson. Every choice gives the result stated in R1 or R6.
- R8: `rst` is synchronous and active high. After an edge that samples it high, `outValid` is low. Operations still in flight at that edge never produce a high `outValid`.
- R9: `result` keeps its value across every edge at which no operation moves from the first stage into the output register. This holds whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears the valid pipeline only |
| inValid | input | 1 | Operands on this cycle form an operation |
| opA | input | N | Multiplicand, unsigned |
| opB | input | N | Multiplier, unsigned; this is the operand that is Booth-recoded |
| addend | input | 2N | Addend, unsigned; ignored when ADDEND_EN=0 |
| outValid | output | 1 | `result` holds a new result this cycle |
| result | output | 2N | Registered A*B+C, modulo 2^(2N) |

## Verification
Two events can fall in the same cycle: a reset edge, and the acceptance or retirement of an operation. To provoke this, the bench issues two back-to-back operations and then raises `rst` while `inValid` is still high, so the reset edge meets one operation in the first stage and a fresh one at the input. The run is judged correct if `outValid` stays low for every following cycle until a new operation is issued. A second overlap is also checked: a result leaving the output register in the same cycle that a new operation enters. Streams with no gaps test this by comparing every cycle's output, in issue order, against the reference computed in the bench.

// File: rtl/mul_add_pkg.sv
package mul_add_pkg;

  // Final carry-propagate network topology
  typedef enum logic [1:0] {
    PFX_KOGGE = 2'd0,
    PFX_BRENT = 2'd1,
    PFX_HAN   = 2'd2
  } prefix_e;

  // Load strobes from control to datapath
  typedef struct packed {
    logic loadStage;
    logic loadOut;
  } strobe_t;

endpackage

// File: rtl/mul_add_ctrl.sv
module mul_add_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output mul_add_pkg::strobe_t strobe,
  output logic                 outValid
);

  logic stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  // data registers carry no reset; only the valid bits do
  assign strobe.loadStage = inValid;
  assign strobe.loadOut   = stageValid;

endmodule

// File: rtl/mul_add_prefix.sv
module mul_add_prefix #(
  parameter int                   W      = 128,
  parameter mul_add_pkg::prefix_e PREFIX = mul_add_pkg::PFX_KOGGE
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  localparam int L = $clog2(W);

  logic [W-1:0] g0;
  logic [W-1:0] p0;

  assign g0 = x & y;
  assign p0 = x ^ y;

  generate
    if (PREFIX == mul_add_pkg::PFX_KOGGE) begin : g_kogge
      always_comb begin
        logic [W-1:0] gv;
        logic [W-1:0] pv;
        gv = g0;
        pv = p0;
        for (int l = 0; l < L; l++) begin
          // descending so each level reads the previous level's spans
          for (int i = W - 1; i >= (1 << l); i--) begin
            gv[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
            pv[i] = pv[i] & pv[i - (1 << l)];
          end
        end
        s = p0 ^ (gv << 1);
      end
    end else if (PREFIX == mul_add_pkg::PFX_BRENT) begin : g_brent
      always_comb begin
        logic [W-1:0] gv;
        logic [W-1:0] pv;
        gv = g0;
        pv = p0;
        // up-sweep: spans double at positions 2d-1, 4d-1, ...
        for (int l = 0; l < L; l++) begin
          for (int i = (2 << l) - 1; i < W; i += (2 << l)) begin
            gv[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
            pv[i] = pv[i] & pv[i - (1 << l)];
          end
        end
        // down-sweep: fill the positions between the finished ones
        for (int l = L - 2; l >= 0; l--) begin
          for (int i = 3 * (1 << l) - 1; i < W; i += (2 << l)) begin
            gv[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
            pv[i] = pv[i] & pv[i - (1 << l)];
          end
        end
        s = p0 ^ (gv << 1);
      end
    end else begin : g_han
      always_comb begin
        logic [W-1:0] gv;
        logic [W-1:0] pv;
        gv = g0;
        pv = p0;
        // pair each odd bit with its even neighbour
        for (int i = 1; i < W; i += 2) begin
          gv[i] = gv[i] | (pv[i] & gv[i - 1]);
          pv[i] = pv[i] & pv[i - 1];
        end
        // sparse Kogge-Stone over odd bits only
        for (int l = 1; l < L; l++) begin
          for (int i = W - 1; i >= (1 << l); i -= 2) begin
            gv[i] = gv[i] | (pv[i] & gv[i - (1 << l)]);
            pv[i] = pv[i] & pv[i - (1 << l)];
          end
        end
        // one extra level resolves the even bits
        for (int i = 2; i < W; i += 2) begin
          gv[i] = gv[i] | (pv[i] & gv[i - 1]);
          pv[i] = pv[i] & pv[i - 1];
        end
        s = p0 ^ (gv << 1);
      end
    end
  endgenerate

endmodule

// File: rtl/mul_add_datapath.sv
module mul_add_datapath #(
  parameter int                   N         = 64,
  parameter bit                   ADDEND_EN = 1'b1,
  parameter mul_add_pkg::prefix_e PREFIX    = mul_add_pkg::PFX_KOGGE
) (
  input  logic                 clk,
  input  mul_add_pkg::strobe_t strobe,
  input  logic [N-1:0]         opA,
  input  logic [N-1:0]         opB,
  input  logic [2*N-1:0]       addend,
  output logic [2*N-1:0]       result
);

  localparam int W      = 2 * N;
  localparam int DIGITS = N / 2 + 1;     // radix-4 digits of zero-extended opB
  localparam int ROWS   = DIGITS + 3;    // digits, sign bits, constant, addend

  function automatic int rowsAt(int lvl);
    int n;
    n = ROWS;
    for (int i = 0; i < lvl; i++) n = (n / 3) * 2 + (n % 3);
    return n;
  endfunction

  function automatic int countLevels();
    int n;
    int l;
    n = ROWS;
    l = 0;
    while (n > 2) begin
      n = (n / 3) * 2 + (n % 3);
      l++;
    end
    return l;
  endfunction

  // Sum of -2^(N+1+2i) over all digit rows, modulo 2^W
  function automatic logic [W-1:0] compConst();
    logic [W-1:0] k;
    k = '0;
    for (int i = 0; i < DIGITS; i++)
      k = k - ({{(W-1){1'b0}}, 1'b1} << (N + 1 + 2 * i));
    return k;
  endfunction

  localparam int           LEVELS = countLevels();
  localparam logic [W-1:0] COMP   = compConst();

  // ---------------- stage 1: Booth partial products ----------------
  logic [W-1:0] ppRow    [ROWS];
  logic [W-1:0] stageRow [ROWS];

  always_comb begin
    logic [N+2:0] bPad;
    logic [2:0]   grp;
    logic         neg;
    logic         one;
    logic         two;
    logic [N:0]   mag;
    logic [N+1:0] body;
    logic [W-1:0] negBits;
    bPad    = {2'b00, opB, 1'b0};
    negBits = '0;
    for (int i = 0; i < DIGITS; i++) begin
      grp  = bPad[2*i +: 3];
      neg  = grp[2] & ~(grp[1] & grp[0]);
      one  = grp[1] ^ grp[0];
      two  = (grp == 3'b011) | (grp == 3'b100);
      mag  = one ? {1'b0, opA} : (two ? {opA, 1'b0} : '0);
      // inverted sign on top; a -2^(N+1) per row is folded into COMP
      body = {~neg, neg ? ~mag : mag};
      ppRow[i]     = W'(body) << (2 * i);
      negBits[2*i] = neg;
    end
    ppRow[DIGITS]     = negBits;
    ppRow[DIGITS + 1] = COMP;
    ppRow[DIGITS + 2] = ADDEND_EN ? addend : '0;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadStage) stageRow <= ppRow;
  end

  // ---------------- stage 2: carry-save tree ----------------
  genvar lv;
  genvar k;
  genvar r;
  generate
    for (lv = 0; lv < LEVELS; lv++) begin : g_lvl
      localparam int NI = rowsAt(lv);
      localparam int NO = rowsAt(lv + 1);
      localparam int NG = NI / 3;
      logic [W-1:0] din  [NI];
      logic [W-1:0] dout [NO];
      if (lv == 0) begin : g_first
        assign din = stageRow;
      end else begin : g_next
        assign din = g_lvl[lv-1].dout;
      end
      for (k = 0; k < NG; k++) begin : g_fa
        assign dout[2*k]   = din[3*k] ^ din[3*k+1] ^ din[3*k+2];
        assign dout[2*k+1] = ((din[3*k] & din[3*k+1]) |
                              (din[3*k] & din[3*k+2]) |
                              (din[3*k+1] & din[3*k+2])) << 1;
      end
      for (r = 0; r < NI - 3 * NG; r++) begin : g_pass
        assign dout[2*NG + r] = din[3*NG + r];
      end
    end
  endgenerate

  logic [W-1:0] sumRow;
  logic [W-1:0] carryRow;
  logic [W-1:0] total;

  assign sumRow   = g_lvl[LEVELS-1].dout[0];
  assign carryRow = g_lvl[LEVELS-1].dout[1];

  mul_add_prefix #(
    .W      (W),
    .PREFIX (PREFIX)
  ) u_prefix (
    .x (sumRow),
    .y (carryRow),
    .s (total)
  );

  always_ff @(posedge clk) begin
    if (strobe.loadOut) result <= total;
  end

endmodule

// File: rtl/mul_add_pipe.sv
module mul_add_pipe #(
  parameter int                   N         = 64,
  parameter bit                   ADDEND_EN = 1'b1,
  parameter mul_add_pkg::prefix_e PREFIX    = mul_add_pkg::PFX_KOGGE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  logic [2*N-1:0] addend,
  output logic           outValid,
  output logic [2*N-1:0] result
);

  mul_add_pkg::strobe_t strobe;

  mul_add_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mul_add_datapath #(
    .N         (N),
    .ADDEND_EN (ADDEND_EN),
    .PREFIX    (PREFIX)
  ) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .addend (addend),
    .result (result)
  );

endmodule

// File: rtl/mul_add_pipe_chk.sv
module mul_add_pipe_chk #(
  parameter int N         = 64,
  parameter bit ADDEND_EN = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic [N-1:0]   opA,
  input logic [N-1:0]   opB,
  input logic [2*N-1:0] addend,
  input logic           outValid,
  input logic [2*N-1:0] result
);

  logic           v1;
  logic           v2;
  logic [2*N-1:0] e0;
  logic [2*N-1:0] e1;
  logic [2*N-1:0] e2;

  // arithmetic reference model
  assign e0 = ({{N{1'b0}}, opA} * {{N{1'b0}}, opB}) +
              (ADDEND_EN ? addend : {2*N{1'b0}});

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
    end
    e1 <= e0;
    e2 <= e1;
  end

  // R2: valid appears exactly two edges after issue
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == v2);

  // R1 / R6: value matches the arithmetic model
  a_r1_value: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (result == e2));

  // R1: no unknown bits on a delivered result
  a_r1_known: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$isunknown(result));

  // R8: reset edge leaves no result valid
  a_r8_reset: assert property (@(posedge clk)
    rst |=> !outValid);

  // R9: result frozen when nothing moves into the output register
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(result));

endmodule

bind mul_add_pipe mul_add_pipe_chk #(
  .N         (N),
  .ADDEND_EN (ADDEND_EN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .addend   (addend),
  .outValid (outValid),
  .result   (result)
);

// File: tb/mul_add_pipe_bench.sv
`timescale 1ns/1ps
module mul_add_pipe_bench;

  typedef struct packed {
    logic [63:0]  a;
    logic [63:0]  b;
    logic [127:0] c;
    logic [127:0] e;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{64'd3, 64'd5, 128'd7, 128'd22},
    '{64'd0, {64{1'b1}}, 128'h0123456789abcdef_fedcba9876543210,
      128'h0123456789abcdef_fedcba9876543210},
    '{{64{1'b1}}, {64{1'b1}}, 128'd0, 128'hfffffffffffffffe_0000000000000001},
    '{{64{1'b1}}, {64{1'b1}}, {128{1'b1}}, 128'hfffffffffffffffe_0000000000000000},
    '{64'h1_0000_0000, 64'h1_0000_0000, 128'd0, 128'h1_0000000000000000},
    '{64'haaaaaaaaaaaaaaaa, 64'd3, 128'd0, 128'h1_fffffffffffffffe},
    '{{64{1'b1}}, 64'd1, {128{1'b1}}, 128'h0000000000000000_fffffffffffffffe},
    '{64'h8000000000000000, 64'd2, 128'd0, 128'h1_0000000000000000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [63:0]  opA = '0;
  logic [63:0]  opB = '0;
  logic [127:0] addend = '0;

  logic         outValid;
  logic [127:0] result;
  logic         bkValid;
  logic [31:0]  bkResult;
  logic         hcValid;
  logic [15:0]  hcResult;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mul_add_pipe u_mul_add_pipe (
    .clk (clk), .rst (rst), .inValid (inValid),
    .opA (opA), .opB (opB), .addend (addend),
    .outValid (outValid), .result (result)
  );

  mul_add_pipe #(.N(16), .ADDEND_EN(1'b0), .PREFIX(mul_add_pkg::PFX_BRENT)) u_mul_add_pipe_bk (
    .clk (clk), .rst (rst), .inValid (inValid),
    .opA (opA[15:0]), .opB (opB[15:0]), .addend (addend[31:0]),
    .outValid (bkValid), .result (bkResult)
  );

  mul_add_pipe #(.N(8), .ADDEND_EN(1'b1), .PREFIX(mul_add_pkg::PFX_HAN)) u_mul_add_pipe_hc (
    .clk (clk), .rst (rst), .inValid (inValid),
    .opA (opA[7:0]), .opB (opB[7:0]), .addend (addend[15:0]),
    .outValid (hcValid), .result (hcResult)
  );

  // expectations for operations two steps back
  logic         hv  [2];
  logic [127:0] hE  [2];
  logic [31:0]  hBk [2];
  logic [15:0]  hHc [2];
  string        hTag[2];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model64(input logic [63:0] a, input logic [63:0] b,
                                           input logic [127:0] c);
    return ({64'd0, a} * {64'd0, b}) + c;
  endfunction

  // One cycle: check the output of the op issued two steps earlier, then drive.
  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic [127:0] c, input logic [127:0] e, input string tag);
    @(negedge clk);
    chk("R2 valid", {127'd0, outValid}, {127'd0, hv[1]});
    chk("R2 valid bk", {127'd0, bkValid}, {127'd0, hv[1]});
    chk("R2 valid hc", {127'd0, hcValid}, {127'd0, hv[1]});
    if (hv[1]) begin
      chk(hTag[1], result, hE[1]);
      chk("R6 multiply-only", {96'd0, bkResult}, {96'd0, hBk[1]});
      chk("R7 han-carlson", {112'd0, hcResult}, {112'd0, hHc[1]});
    end
    hv[1] = hv[0]; hE[1] = hE[0]; hBk[1] = hBk[0]; hHc[1] = hHc[0]; hTag[1] = hTag[0];
    hv[0]  = v;
    hE[0]  = e;
    hBk[0] = {16'd0, a[15:0]} * {16'd0, b[15:0]};
    hHc[0] = ({8'd0, a[7:0]} * {8'd0, b[7:0]}) + c[15:0];
    hTag[0] = tag;
    inValid = v;
    opA = a;
    opB = b;
    addend = c;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] held;
    logic [31:0]  heldBk;
    logic [15:0]  heldHc;
    hv[0] = 1'b0; hv[1] = 1'b0;

    // reset state (R8)
    repeat (3) @(negedge clk);
    chk("R8 reset outValid", {127'd0, outValid}, 128'd0);
    chk("R8 reset outValid bk", {127'd0, bkValid}, 128'd0);
    rst = 1'b0;

    // table walk, back to back (R1, R4, R5, R7 KS)
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].e,
           (i == 3) ? "R4 wrap" : ((i == 1) ? "R5 zero operand" : "R1 table"));
    end

    // random stream with gaps, including all-zero B (R3, R5)
    for (int i = 0; i < 300; i++) begin
      logic [63:0]  a;
      logic [63:0]  b;
      logic [127:0] c;
      logic         v;
      a = rnd64();
      b = (i % 37 == 5) ? 64'd0 : rnd64();
      c = {rnd64(), rnd64()};
      v = (i < 100) ? 1'b1 : ($urandom_range(0, 3) != 0);
      step(v, a, b, c, model64(a, b, c), (b == 64'd0) ? "R5 zero b" : "R3 stream");
    end

    // drain, then hold with noisy operands (R9)
    step(1'b0, '0, '0, '0, '0, "R9");
    step(1'b0, '0, '0, '0, '0, "R9");
    step(1'b0, '0, '0, '0, '0, "R9");
    held = result; heldBk = bkResult; heldHc = hcResult;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, rnd64(), rnd64(), {rnd64(), rnd64()}, '0, "R9");
      chk("R9 hold", result, held);
      chk("R9 hold bk", {96'd0, bkResult}, {96'd0, heldBk});
      chk("R9 hold hc", {112'd0, hcResult}, {112'd0, heldHc});
    end

    // reset meeting ops in flight and a new issue (R8)
    step(1'b1, 64'd7, 64'd9, 128'd1, 128'd64, "R1 pre-reset");
    step(1'b1, 64'd11, 64'd13, 128'd2, 128'd145, "R1 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    hv[0] = 1'b0; hv[1] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 flushed", {127'd0, outValid}, 128'd0);
      chk("R8 flushed hc", {127'd0, hcValid}, 128'd0);
    end

    // recovery after reset (R2)
    step(1'b1, 64'd6, 64'd7, 128'd8, 128'd50, "R2 after reset");
    step(1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, '0, '0, '0, '0, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule